// File: doc/BRIEF.md
# Split Word Port

This block sits between a requester that issues byte and word reads and writes on a 20-bit byte address and a 16-bit memory port with two byte lanes. It turns each request into memory cycles of a fixed four-clock length. Words are little-endian: the less significant byte sits at the lower byte address.

A word at an even address uses both lanes in one cycle. A word at an odd address is allowed and costs one extra cycle. The first cycle writes or reads the high lane of the word that holds address A. The second cycle uses the low lane of the word that holds A+1, and the address wraps from 0xFFFFF to 0x00000. Read halves are put back together before the result is returned with a one-clock valid strobe. A byte access always takes one cycle. While a request is in flight, `busy` is high and new requests are not taken.

The controller has three states. In `ST_IDLE` it waits. It enters `ST_FIRST` when a request is accepted. `ST_FIRST` moves to `ST_SECOND` at the end of its cycle when the request is an odd word, and otherwise returns to `ST_IDLE`. `ST_SECOND` always returns to `ST_IDLE` at the end of its cycle.

Top module: `split_word_port`

## Requirements
- R1: After reset, `busy`, `mem_cyc`, `mem_last` and `rd_valid` are all low.
- R2: Every memory cycle keeps `mem_cyc` high for exactly 4 consecutive clocks, with `mem_last` high only in the fourth. `mem_addr`, `mem_lane`, `mem_we` and `mem_wdata` hold steady across those clocks.
- R3: A word at an even byte address A takes one cycle at word address A[19:1] with `mem_lane` = 2'b11. Write data goes out unchanged, and read data is `mem_rdata` unchanged.
- R4: A word at an odd byte address A takes two back-to-back cycles. The first is at A[19:1] with `mem_lane` = 2'b10 and the low data byte on bits 15:8. The second is at (A+1)[19:1] with `mem_lane` = 2'b01 and the high data byte on bits 7:0.
- R5: An odd-word read returns bits 15:8 of the first cycle's `mem_rdata` as rd_data[7:0] and bits 7:0 of the second cycle's `mem_rdata` as rd_data[15:8].
- R6: A byte access takes one cycle. It uses `mem_lane` = 2'b01 (bits 7:0) when A[0]=0 and 2'b10 (bits 15:8) when A[0]=1. A byte write copies the byte onto both halves of `mem_wdata`. A byte read returns the selected byte in rd_data[7:0] with rd_data[15:8] zero.
- R7: An odd word at 0xFFFFF has its second cycle at word address 0.
- R8: `busy` is high from the clock after a request is accepted through the final fourth clock. A request presented while `busy` is high is ignored and produces no memory cycle.
- R9: `rd_valid` pulses for exactly one clock, the clock after the final `mem_last` of a read. It never pulses for a write.
- R10: `busy` lasts 4 clocks for bytes and even words and 8 clocks for odd words, with no idle clock between the two cycles of an odd word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; taken when `busy` is low |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = word access, 0 = byte access |
| req_addr | input | 20 | Byte address |
| req_wdata | input | 16 | Write data (byte in bits 7:0 for byte writes) |
| busy | output | 1 | Request in flight |
| rd_valid | output | 1 | One-clock strobe for read data |
| rd_data | output | 16 | Read result |
| mem_cyc | output | 1 | Memory cycle active |
| mem_last | output | 1 | Fourth clock of a memory cycle; read data is taken here |
| mem_addr | output | 19 | Word address on the memory port |
| mem_lane | output | 2 | Byte-lane enables: bit 0 for bits 7:0, bit 1 for bits 15:8 |
| mem_we | output | 1 | Cycle is a write, committed on `mem_last` |
| mem_wdata | output | 16 | Write data on the lanes |
| mem_rdata | input | 16 | Read data from the memory port |

## Verification
The bench runs word writes and reads at an even address, at an odd address, and across the top of the address space. Even words show that one full-width cycle is used. Odd words show that the lanes are ordered and the bytes swapped correctly, and the wrapping case shows that the address increment carries to zero. Byte accesses at both parities separate lane choice and copying on writes from zero extension on reads. A request injected while `busy` is high shows it leaves no trace in memory or on the port.

// File: rtl/split_word_pkg.sv
package split_word_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FIRST  = 2'd1,
        ST_SECOND = 2'd2
    } split_state_e;

    typedef enum logic [1:0] {
        ACC_BYTE     = 2'd0,
        ACC_WORD_EVN = 2'd1,
        ACC_WORD_ODD = 2'd2
    } access_kind_e;

    localparam int LANES = 2;

    localparam logic [LANES-1:0] LANE_LO   = 2'b01;
    localparam logic [LANES-1:0] LANE_HI   = 2'b10;
    localparam logic [LANES-1:0] LANE_BOTH = 2'b11;

endpackage

// File: rtl/split_word_decode.sv
module split_word_decode
    import split_word_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              word,
    input  logic [ADDR_W-1:0] addr,
    output access_kind_e      kind,
    output logic [ADDR_W-2:0] waddr_first,
    output logic [ADDR_W-2:0] waddr_second,
    output logic [LANES-1:0]  lane_first,
    output logic [LANES-1:0]  lane_second
);

    logic [ADDR_W-1:0] addr_next;

    // Carry past the top of the space wraps to zero.
    assign addr_next = addr + ADDR_W'(1);

    always_comb begin
        if (!word) begin
            kind = ACC_BYTE;
        end else if (addr[0]) begin
            kind = ACC_WORD_ODD;
        end else begin
            kind = ACC_WORD_EVN;
        end
    end

    assign waddr_first  = addr[ADDR_W-1:1];
    assign waddr_second = addr_next[ADDR_W-1:1];

    always_comb begin
        lane_second = LANE_LO;
        unique case (kind)
            ACC_BYTE:     lane_first = addr[0] ? LANE_HI : LANE_LO;
            ACC_WORD_EVN: lane_first = LANE_BOTH;
            ACC_WORD_ODD: lane_first = LANE_HI;
            default:      lane_first = LANE_BOTH;
        endcase
    end

endmodule

// File: rtl/split_word_pacer.sv
module split_word_pacer #(
    parameter int CYC_CLKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic last
);

    localparam int PH_W = (CYC_CLKS > 1) ? $clog2(CYC_CLKS) : 1;
    localparam logic [PH_W-1:0] PH_END = PH_W'(CYC_CLKS - 1);

    logic [PH_W-1:0] phase;

    assign last = run && (phase == PH_END);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (!run || last) begin
            phase <= '0;
        end else begin
            phase <= phase + PH_W'(1);
        end
    end

endmodule

// File: rtl/split_word_lanes.sv
module split_word_lanes
    import split_word_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                  active,
    input  logic                  second,
    input  access_kind_e          kind,
    input  logic [2*BYTE_W-1:0]   wdata,
    output logic [2*BYTE_W-1:0]   lane_data
);

    logic [BYTE_W-1:0] lo_byte;
    logic [BYTE_W-1:0] hi_byte;

    assign lo_byte = wdata[BYTE_W-1:0];
    assign hi_byte = wdata[2*BYTE_W-1:BYTE_W];

    always_comb begin
        lane_data = '0;
        if (active) begin
            unique case (kind)
                ACC_BYTE:     lane_data = {lo_byte, lo_byte};
                ACC_WORD_EVN: lane_data = wdata;
                ACC_WORD_ODD: lane_data = second ? {{BYTE_W{1'b0}}, hi_byte}
                                                 : {lo_byte, {BYTE_W{1'b0}}};
                default:      lane_data = wdata;
            endcase
        end
    end

endmodule

// File: rtl/split_word_gather.sv
module split_word_gather
    import split_word_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                capture,
    input  logic                second,
    input  access_kind_e        kind,
    input  logic                addr_lsb,
    input  logic [2*BYTE_W-1:0] rdata,
    output logic                rd_valid,
    output logic [2*BYTE_W-1:0] rd_data
);

    logic [BYTE_W-1:0] lo_hold;
    logic [BYTE_W-1:0] rd_lo;
    logic [BYTE_W-1:0] rd_hi;
    logic              final_cap;

    assign rd_lo = rdata[BYTE_W-1:0];
    assign rd_hi = rdata[2*BYTE_W-1:BYTE_W];
    assign final_cap = capture && ((kind != ACC_WORD_ODD) || second);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_hold <= '0;
        end else if (capture && !second && kind == ACC_WORD_ODD) begin
            lo_hold <= rd_hi;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= final_cap;
            if (final_cap) begin
                unique case (kind)
                    ACC_BYTE:     rd_data <= {{BYTE_W{1'b0}}, addr_lsb ? rd_hi : rd_lo};
                    ACC_WORD_EVN: rd_data <= rdata;
                    ACC_WORD_ODD: rd_data <= {rd_lo, lo_hold};
                    default:      rd_data <= rdata;
                endcase
            end
        end
    end

endmodule

// File: rtl/split_word_port.sv
module split_word_port
    import split_word_pkg::*;
#(
    parameter int ADDR_W   = 20,
    parameter int BYTE_W   = 8,
    parameter int CYC_CLKS = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic                req_word,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [2*BYTE_W-1:0] req_wdata,
    output logic                busy,
    output logic                rd_valid,
    output logic [2*BYTE_W-1:0] rd_data,
    output logic                mem_cyc,
    output logic                mem_last,
    output logic [ADDR_W-2:0]   mem_addr,
    output logic [1:0]          mem_lane,
    output logic                mem_we,
    output logic [2*BYTE_W-1:0] mem_wdata,
    input  logic [2*BYTE_W-1:0] mem_rdata
);

    localparam int DATA_W = 2 * BYTE_W;

    split_state_e      state_q;
    split_state_e      state_d;
    logic              accept;
    logic              cyc_end;
    logic              in_second;

    logic              we_q;
    logic              word_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;

    access_kind_e      kind;
    logic [ADDR_W-2:0] waddr_first;
    logic [ADDR_W-2:0] waddr_second;
    logic [LANES-1:0]  lane_first;
    logic [LANES-1:0]  lane_second;

    assign accept    = (state_q == ST_IDLE) && req_valid;
    assign in_second = (state_q == ST_SECOND);

    // Request hold register: loaded only when a request is taken.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_q    <= 1'b0;
            word_q  <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            we_q    <= req_write;
            word_q  <= req_word;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    split_word_decode #(
        .ADDR_W (ADDR_W)
    ) u_decode (
        .word         (word_q),
        .addr         (addr_q),
        .kind         (kind),
        .waddr_first  (waddr_first),
        .waddr_second (waddr_second),
        .lane_first   (lane_first),
        .lane_second  (lane_second)
    );

    split_word_pacer #(
        .CYC_CLKS (CYC_CLKS)
    ) u_pacer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (mem_cyc),
        .last  (cyc_end)
    );

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    state_d = ST_FIRST;
                end
            end
            ST_FIRST: begin
                if (cyc_end) begin
                    state_d = (kind == ACC_WORD_ODD) ? ST_SECOND : ST_IDLE;
                end
            end
            ST_SECOND: begin
                if (cyc_end) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Port outputs decoded from the state.
    always_comb begin
        mem_cyc  = 1'b0;
        mem_addr = '0;
        mem_lane = '0;
        unique case (state_q)
            ST_IDLE: begin
                mem_cyc = 1'b0;
            end
            ST_FIRST: begin
                mem_cyc  = 1'b1;
                mem_addr = waddr_first;
                mem_lane = lane_first;
            end
            ST_SECOND: begin
                mem_cyc  = 1'b1;
                mem_addr = waddr_second;
                mem_lane = lane_second;
            end
            default: mem_cyc = 1'b0;
        endcase
        busy     = mem_cyc;
        mem_we   = mem_cyc && we_q;
        mem_last = cyc_end;
    end

    split_word_lanes #(
        .BYTE_W (BYTE_W)
    ) u_lanes (
        .active    (mem_cyc && we_q),
        .second    (in_second),
        .kind      (kind),
        .wdata     (wdata_q),
        .lane_data (mem_wdata)
    );

    split_word_gather #(
        .BYTE_W (BYTE_W)
    ) u_gather (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (cyc_end && !we_q),
        .second   (in_second),
        .kind     (kind),
        .addr_lsb (addr_q[0]),
        .rdata    (mem_rdata),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

endmodule

// File: rtl/split_word_checker.sv
module split_word_checker #(
    parameter int ADDR_W   = 20,
    parameter int BYTE_W   = 8,
    parameter int CYC_CLKS = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                busy,
    input logic                rd_valid,
    input logic                mem_cyc,
    input logic                mem_last,
    input logic [ADDR_W-2:0]   mem_addr,
    input logic [1:0]          mem_lane,
    input logic                mem_we,
    input logic [2*BYTE_W-1:0] mem_wdata
);

    localparam int CW = $clog2(CYC_CLKS + 1) + 1;

    logic [CW-1:0] run_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (mem_cyc && !mem_last) begin
            run_cnt <= run_cnt + CW'(1);
        end else begin
            run_cnt <= '0;
        end
    end

    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (!busy && !mem_cyc && !mem_last && !rd_valid));

    p_last_on_fourth_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cyc |-> (mem_last == (run_cnt == CW'(CYC_CLKS - 1))));

    p_port_steady_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_cyc && !mem_last) |=> (mem_cyc && $stable(mem_addr) && $stable(mem_lane)
                                    && $stable(mem_we) && $stable(mem_wdata)));

    // R4, R7: a cycle that follows another at once is the upper half of an odd word.
    p_second_half_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mem_last) && mem_cyc) |-> ($past(mem_lane) == 2'b10 && mem_lane == 2'b01
                                          && mem_addr == $past(mem_addr) + 1'b1));

    p_lane_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cyc |-> (mem_lane != 2'b00));

    p_busy_covers_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cyc |-> busy);

    p_rdv_after_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ($past(mem_last) && !$past(mem_we) && !mem_cyc));

endmodule

bind split_word_port split_word_checker #(
    .ADDR_W   (ADDR_W),
    .BYTE_W   (BYTE_W),
    .CYC_CLKS (CYC_CLKS)
) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .rd_valid  (rd_valid),
    .mem_cyc   (mem_cyc),
    .mem_last  (mem_last),
    .mem_addr  (mem_addr),
    .mem_lane  (mem_lane),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata)
);

// File: tb/split_word_port_bench.sv
`timescale 1ns/1ps
module split_word_port_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_word = 1'b0;
    logic [19:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        busy, rd_valid, mem_cyc, mem_last, mem_we;
    logic [15:0] rd_data, mem_wdata, mem_rdata;
    logic [18:0] mem_addr;
    logic [1:0]  mem_lane;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    split_word_port u_split_word_port (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_word(req_word), .req_addr(req_addr), .req_wdata(req_wdata),
        .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data), .mem_cyc(mem_cyc),
        .mem_last(mem_last), .mem_addr(mem_addr), .mem_lane(mem_lane),
        .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // Memory model: 512 bytes indexed by the low 8 word-address bits.
    logic [7:0] bmem [512];
    assign mem_rdata = {bmem[{mem_addr[7:0], 1'b1}], bmem[{mem_addr[7:0], 1'b0}]};

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 512; i++) bmem[i] <= 8'h00;
        end else if (mem_cyc && mem_last && mem_we) begin
            if (mem_lane[0]) bmem[{mem_addr[7:0], 1'b0}] <= mem_wdata[7:0];
            if (mem_lane[1]) bmem[{mem_addr[7:0], 1'b1}] <= mem_wdata[15:8];
        end
    end

    // Cycle log.
    logic [18:0] lg_addr [64];
    logic [1:0]  lg_lane [64];
    logic        lg_we   [64];
    logic [15:0] lg_wd   [64];
    int          lg_len  [64];
    int          lg_n = 0;
    int          run = 0;

    always @(posedge clk) begin
        if (mem_cyc) begin
            if (mem_last) begin
                lg_addr[lg_n % 64] <= mem_addr;
                lg_lane[lg_n % 64] <= mem_lane;
                lg_we[lg_n % 64]   <= mem_we;
                lg_wd[lg_n % 64]   <= mem_wdata;
                lg_len[lg_n % 64]  <= run + 1;
                lg_n <= lg_n + 1;
                run  <= 0;
            end else begin
                run <= run + 1;
            end
        end else begin
            run <= 0;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    int         r_busy;
    bit         r_valid;
    logic [15:0] r_data;
    bit         r_pulse;
    int         r_base;

    task automatic issue(input bit wr, input bit wd, input logic [19:0] a,
                         input logic [15:0] d);
        @(negedge clk);
        r_base = lg_n;
        req_valid = 1'b1; req_write = wr; req_word = wd; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        r_busy = 0;
        while (busy) begin
            r_busy++;
            @(negedge clk);
        end
        r_valid = rd_valid;
        r_data  = rd_data;
        @(negedge clk);
        r_pulse = !rd_valid;
    endtask

    task automatic chk_cyc(input int k, input string req, input logic [18:0] wa,
                           input logic [1:0] ln, input bit we);
        int j = (r_base + k) % 64;
        chk(lg_addr[j] == wa, req, "word address", int'(lg_addr[j]), int'(wa));
        chk(lg_lane[j] == ln, req, "lane", int'(lg_lane[j]), int'(ln));
        chk(lg_we[j] == we, req, "write enable", int'(lg_we[j]), int'(we));
        chk(lg_len[j] == 4, "R2", "cycle length", lg_len[j], 4);
    endtask

    task automatic t_reset();
        chk(!busy, "R1", "busy after reset", int'(busy), 0);
        chk(!mem_cyc && !mem_last, "R1", "port idle after reset", int'(mem_cyc), 0);
        chk(!rd_valid, "R1", "rd_valid after reset", int'(rd_valid), 0);
    endtask

    task automatic t_even_word();
        issue(1'b1, 1'b1, 20'h00010, 16'hBEEF);
        chk(lg_n - r_base == 1, "R3", "even write cycle count", lg_n - r_base, 1);
        chk_cyc(0, "R3", 19'h00008, 2'b11, 1'b1);
        chk(lg_wd[r_base % 64] == 16'hBEEF, "R3", "even write data",
            int'(lg_wd[r_base % 64]), 16'hBEEF);
        chk(r_busy == 4, "R10", "even busy clocks", r_busy, 4);
        chk(!r_valid, "R9", "no rd_valid on write", int'(r_valid), 0);
        issue(1'b0, 1'b1, 20'h00010, 16'h0000);
        chk(r_valid && r_data == 16'hBEEF, "R3", "even read data", int'(r_data), 16'hBEEF);
        chk(r_pulse, "R9", "rd_valid one clock", int'(!r_pulse), 0);
        chk(lg_n - r_base == 1, "R3", "even read cycle count", lg_n - r_base, 1);
    endtask

    task automatic t_odd_word();
        issue(1'b1, 1'b1, 20'h00021, 16'h1234);
        chk(lg_n - r_base == 2, "R4", "odd write cycle count", lg_n - r_base, 2);
        chk_cyc(0, "R4", 19'h00010, 2'b10, 1'b1);
        chk_cyc(1, "R4", 19'h00011, 2'b01, 1'b1);
        chk(lg_wd[r_base % 64][15:8] == 8'h34, "R4", "first cycle low byte",
            int'(lg_wd[r_base % 64][15:8]), 8'h34);
        chk(lg_wd[(r_base + 1) % 64][7:0] == 8'h12, "R4", "second cycle high byte",
            int'(lg_wd[(r_base + 1) % 64][7:0]), 8'h12);
        chk(bmem[9'h021] == 8'h34 && bmem[9'h022] == 8'h12, "R4", "bytes in memory",
            int'({bmem[9'h022], bmem[9'h021]}), 16'h1234);
        chk(bmem[9'h020] == 8'h00 && bmem[9'h023] == 8'h00, "R4", "neighbours untouched",
            int'({bmem[9'h023], bmem[9'h020]}), 0);
        chk(r_busy == 8, "R10", "odd busy clocks", r_busy, 8);
        issue(1'b0, 1'b1, 20'h00021, 16'h0000);
        chk(r_valid && r_data == 16'h1234, "R5", "odd read reassembly", int'(r_data), 16'h1234);
        chk(r_pulse, "R9", "odd read rd_valid one clock", int'(!r_pulse), 0);
        chk(r_busy == 8, "R10", "odd read busy clocks", r_busy, 8);
    endtask

    task automatic t_bytes();
        issue(1'b1, 1'b0, 20'h00031, 16'h00A5);
        chk_cyc(0, "R6", 19'h00018, 2'b10, 1'b1);
        chk(lg_wd[r_base % 64] == 16'hA5A5, "R6", "byte copied to both halves",
            int'(lg_wd[r_base % 64]), 16'hA5A5);
        chk(bmem[9'h030] == 8'h00 && bmem[9'h031] == 8'hA5, "R6", "odd byte lane only",
            int'({bmem[9'h031], bmem[9'h030]}), 16'hA500);
        chk(r_busy == 4, "R10", "byte busy clocks", r_busy, 4);
        issue(1'b1, 1'b0, 20'h00040, 16'hFF5C);
        chk_cyc(0, "R6", 19'h00020, 2'b01, 1'b1);
        chk(bmem[9'h040] == 8'h5C && bmem[9'h041] == 8'h00, "R6", "even byte lane only",
            int'({bmem[9'h041], bmem[9'h040]}), 16'h005C);
        issue(1'b0, 1'b0, 20'h00031, 16'h0000);
        chk(r_valid && r_data == 16'h00A5, "R6", "odd byte read", int'(r_data), 16'h00A5);
        issue(1'b0, 1'b0, 20'h00022, 16'h0000);
        chk(r_valid && r_data == 16'h0012, "R6", "even byte read", int'(r_data), 16'h0012);
    endtask

    task automatic t_wrap();
        issue(1'b1, 1'b1, 20'hFFFFF, 16'hCAFE);
        chk_cyc(0, "R7", 19'h7FFFF, 2'b10, 1'b1);
        chk_cyc(1, "R7", 19'h00000, 2'b01, 1'b1);
        issue(1'b0, 1'b1, 20'hFFFFF, 16'h0000);
        chk(r_valid && r_data == 16'hCAFE, "R7", "wrapped read", int'(r_data), 16'hCAFE);
    endtask

    task automatic t_busy_ignore();
        @(negedge clk);
        r_base = lg_n;
        req_valid = 1'b1; req_write = 1'b0; req_word = 1'b1; req_addr = 20'h00010;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy, "R8", "busy after accept", int'(busy), 1);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_word = 1'b1;
        req_addr = 20'h00050; req_wdata = 16'h7777;
        @(negedge clk);
        req_valid = 1'b0;
        while (busy) @(negedge clk);
        chk(rd_valid && rd_data == 16'hBEEF, "R8", "first request completes",
            int'(rd_data), 16'hBEEF);
        repeat (3) @(negedge clk);
        chk(!busy && lg_n - r_base == 1, "R8", "ignored request made no cycle",
            lg_n - r_base, 1);
        chk(bmem[9'h050] == 8'h00 && bmem[9'h051] == 8'h00, "R8", "ignored write absent",
            int'({bmem[9'h051], bmem[9'h050]}), 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_even_word();
        t_odd_word();
        t_bytes();
        t_wrap();
        t_busy_ignore();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule